// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block ranks the interrupt sources of a 16550-style UART receiver and transmitter and presents the result as a 32-bit identification word plus a single interrupt request line. Its inputs are raw conditions from the surrounding UART: a vector of receive error flags, receive-data-available at the FIFO trigger level, character time-out, transmit holding register empty, and the two auto-baud events (completion and time-out). Per-source enables, the FIFO enable bit and the read strobes of the identification and line status registers complete the interface.

The identification word carries an active-low pending flag, a 3-bit priority code for the highest enabled pending source, two copies of the FIFO enable bit and two sticky auto-baud flags. While software holds a read of the word, the word is frozen. Anything that happens meanwhile is recorded internally and shows on the next read. Receive-line-status is cleared by the line status read. A transmit-empty interrupt is cleared by a read that reported it or by a new write to the transmit holding register. The auto-baud flags are cleared by their own clear strobes.

Top module: `uart_iid_ident`

## Requirements
- R1: After reset `iir_o` reads 0x00000001 and `irq_o` is 0.
- R2: Bit 0 of `iir_o` is 0 when at least one enabled non-auto-baud source is pending and 1 otherwise. When it is 1, bits 3:1 read 000.
- R3: Bits 3:1 carry the code of the highest-priority enabled pending source. From highest to lowest the sources and codes are: line status 011, data available 010, character time-out 110, transmit empty 001. No other code appears while bit 0 is 0.
- R4: The line-status source goes pending when any bit of `rls_err_i` is 1. The bits are [0] overrun, [1] parity, [2] framing and [3] break. It stays pending until `lsr_rd_i`, and a read of `iir_o` does not clear it.
- R5: While `iir_rd_i` stays high, `iir_o` holds the value it had in the cycle before the read began. A source that becomes pending during the read shows in `iir_o` one cycle after `iir_rd_i` falls.
- R6: Bits 7 and 6 both copy `fifo_en_i`. Bits 5:4 and bits REG_W-1:10 read 0.
- R7: Bit 8 (auto-baud done) is set by `abeo_evt_i` and bit 9 (auto-baud time-out) is set by `abto_evt_i`, each only while its enable is 1. Each stays set, including through reads, until its own clear strobe. Neither flag changes bits 3:0.
- R8: Data available and character time-out follow their input levels. Reading `iir_o` does not clear them, and they drop when the input drops.
- R9: Transmit empty goes pending on a 0-to-1 change of `thre_i`. It is cleared by a read that showed code 001 or by `thr_wr_i`. It does not return while `thre_i` stays 1, and a read that showed another code leaves it pending.
- R10: A source takes part in ranking only while its enable is 1. `ier_rx_i` covers both data available and time-out. `irq_o` is 1 exactly when an enabled source is pending or either auto-baud flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rls_err_i | input | N_ERR | Receive error flags: overrun, parity, framing, break |
| rda_i | input | 1 | Receive FIFO at or above trigger level |
| cti_i | input | 1 | Character time-out condition |
| thre_i | input | 1 | Transmit holding register empty level |
| thr_wr_i | input | 1 | Write strobe of the transmit holding register |
| abeo_evt_i | input | 1 | Auto-baud completed event |
| abto_evt_i | input | 1 | Auto-baud time-out event |
| abeo_clr_i | input | 1 | Clear strobe for the auto-baud done flag |
| abto_clr_i | input | 1 | Clear strobe for the auto-baud time-out flag |
| ier_rls_i | input | 1 | Enable for line-status interrupt |
| ier_rx_i | input | 1 | Enable for data-available and time-out interrupts |
| ier_thre_i | input | 1 | Enable for transmit-empty interrupt |
| ier_abeo_i | input | 1 | Enable for auto-baud done flag |
| ier_abto_i | input | 1 | Enable for auto-baud time-out flag |
| fifo_en_i | input | 1 | FIFO enable bit, mirrored in bits 7:6 |
| iir_rd_i | input | 1 | High for the duration of an identification read |
| lsr_rd_i | input | 1 | Read strobe of the line status register |
| iir_o | output | REG_W | Identification word |
| irq_o | output | 1 | Interrupt request |

## Verification
A level input (data available, time-out, FIFO enable) reaches `iir_o` at the first clock edge after it is driven. A latched source (line error, transmit empty, auto-baud) needs two edges: one to set its latch and one to load the word. `irq_o` is combinational from the latches, so it responds to a latched source after one edge and to a level input at once. The bench drives on the falling edge and waits at least two rising edges before it samples. In the freeze test it samples `iir_o` during the held read and again exactly one edge after the strobe drops. A sweep over every combination of three enables and four sources compares the word and request line with a priority model computed in the bench.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

   typedef enum logic [2:0] {
      IID_NONE = 3'b000,
      IID_THRE = 3'b001,
      IID_RDA  = 3'b010,
      IID_RLS  = 3'b011,
      IID_CTI  = 3'b110
   } iid_code_e;

   typedef struct packed {
      logic rls;
      logic rda;
      logic cti;
      logic thre;
   } iid_src_t;

   localparam int unsigned MIN_REG_W = 10;
   localparam int unsigned AB_FLAGS  = 2;

endpackage

// File: rtl/uart_iid_src.sv
module uart_iid_src
   import uart_iid_pkg::*;
#(
   parameter int unsigned N_ERR = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_ERR-1:0]    rls_err_i,
   input  logic                lsr_rd_i,
   input  logic                thre_i,
   input  logic                thr_wr_i,
   input  logic                thre_ack_i,
   input  logic [AB_FLAGS-1:0] ab_evt_i,
   input  logic [AB_FLAGS-1:0] ab_en_i,
   input  logic [AB_FLAGS-1:0] ab_clr_i,
   output logic                rls_pend_o,
   output logic                thre_pend_o,
   output logic [AB_FLAGS-1:0] ab_flag_o
);

   logic thre_q;
   logic thre_rise;

   assign thre_rise = thre_i & ~thre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rls_pend_o <= 1'b0;
      end else if (|rls_err_i) begin
         rls_pend_o <= 1'b1;
      end else if (lsr_rd_i) begin
         rls_pend_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thre_q      <= 1'b0;
         thre_pend_o <= 1'b0;
      end else begin
         thre_q <= thre_i;
         if (thre_rise) begin
            thre_pend_o <= 1'b1;
         end else if (thr_wr_i || thre_ack_i) begin
            thre_pend_o <= 1'b0;
         end
      end
   end

   for (genvar k = 0; k < AB_FLAGS; k++) begin : g_ab
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ab_flag_o[k] <= 1'b0;
         end else if (ab_evt_i[k] && ab_en_i[k]) begin
            ab_flag_o[k] <= 1'b1;
         end else if (ab_clr_i[k]) begin
            ab_flag_o[k] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
   import uart_iid_pkg::*;
(
   input  iid_src_t  src_i,
   input  logic      en_rls_i,
   input  logic      en_rx_i,
   input  logic      en_thre_i,
   output iid_code_e code_o,
   output logic      pend_o
);

   iid_src_t act;

   always_comb begin
      act.rls  = src_i.rls  & en_rls_i;
      act.rda  = src_i.rda  & en_rx_i;
      act.cti  = src_i.cti  & en_rx_i;
      act.thre = src_i.thre & en_thre_i;
   end

   always_comb begin
      if (act.rls) begin
         code_o = IID_RLS;
      end else if (act.rda) begin
         code_o = IID_RDA;
      end else if (act.cti) begin
         code_o = IID_CTI;
      end else if (act.thre) begin
         code_o = IID_THRE;
      end else begin
         code_o = IID_NONE;
      end
   end

   assign pend_o = |act;

endmodule

// File: rtl/uart_iid_snap.sv
module uart_iid_snap #(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] live_i,
   input  logic             rd_i,
   output logic [REG_W-1:0] word_o,
   output logic             rd_start_o
);

   localparam logic [REG_W-1:0] RST_WORD = REG_W'(1);

   logic rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= RST_WORD;
         rd_q   <= 1'b0;
      end else begin
         rd_q <= rd_i;
         if (!rd_i) begin
            word_o <= live_i;
         end
      end
   end

   assign rd_start_o = rd_i & ~rd_q;

endmodule

// File: rtl/uart_iid_ident.sv
module uart_iid_ident
   import uart_iid_pkg::*;
#(
   parameter int unsigned REG_W = 32,
   parameter int unsigned N_ERR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_ERR-1:0] rls_err_i,
   input  logic             rda_i,
   input  logic             cti_i,
   input  logic             thre_i,
   input  logic             thr_wr_i,
   input  logic             abeo_evt_i,
   input  logic             abto_evt_i,
   input  logic             abeo_clr_i,
   input  logic             abto_clr_i,
   input  logic             ier_rls_i,
   input  logic             ier_rx_i,
   input  logic             ier_thre_i,
   input  logic             ier_abeo_i,
   input  logic             ier_abto_i,
   input  logic             fifo_en_i,
   input  logic             iir_rd_i,
   input  logic             lsr_rd_i,
   output logic [REG_W-1:0] iir_o,
   output logic             irq_o
);

   localparam int unsigned CODE_LSB = 1;
   localparam int unsigned FIFO_LSB = 6;
   localparam int unsigned AB_LSB   = 8;

   if (REG_W < MIN_REG_W) begin : g_bad_width
      $error("uart_iid_ident: REG_W must be at least %0d", MIN_REG_W);
   end
   if (N_ERR < 1) begin : g_bad_err
      $error("uart_iid_ident: N_ERR must be at least 1");
   end

   logic                rls_pend;
   logic                thre_pend;
   logic                thre_ack;
   logic                rd_start;
   logic                std_pend;
   logic [AB_FLAGS-1:0] ab_flag;
   iid_code_e           code;
   iid_src_t            src;
   logic [REG_W-1:0]    live;

   uart_iid_src #(.N_ERR(N_ERR)) src_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .rls_err_i   (rls_err_i),
      .lsr_rd_i    (lsr_rd_i),
      .thre_i      (thre_i),
      .thr_wr_i    (thr_wr_i),
      .thre_ack_i  (thre_ack),
      .ab_evt_i    ({abto_evt_i, abeo_evt_i}),
      .ab_en_i     ({ier_abto_i, ier_abeo_i}),
      .ab_clr_i    ({abto_clr_i, abeo_clr_i}),
      .rls_pend_o  (rls_pend),
      .thre_pend_o (thre_pend),
      .ab_flag_o   (ab_flag)
   );

   always_comb begin
      src.rls  = rls_pend;
      src.rda  = rda_i;
      src.cti  = cti_i;
      src.thre = thre_pend;
   end

   uart_iid_prio prio_i (
      .src_i     (src),
      .en_rls_i  (ier_rls_i),
      .en_rx_i   (ier_rx_i),
      .en_thre_i (ier_thre_i),
      .code_o    (code),
      .pend_o    (std_pend)
   );

   always_comb begin
      live                              = '0;
      live[0]                           = ~std_pend;
      live[CODE_LSB +: 3]               = code;
      live[FIFO_LSB +: 2]               = {2{fifo_en_i}};
      live[AB_LSB +: AB_FLAGS]          = ab_flag;
   end

   uart_iid_snap #(.REG_W(REG_W)) snap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .live_i     (live),
      .rd_i       (iir_rd_i),
      .word_o     (iir_o),
      .rd_start_o (rd_start)
   );

   assign thre_ack = rd_start & ~iir_o[0] & (iir_o[CODE_LSB +: 3] == IID_THRE);
   assign irq_o    = std_pend | (|ab_flag);

endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned N_ERR = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] iir_o,
   input logic             irq_o,
   input logic             iir_rd_i,
   input logic [N_ERR-1:0] rls_err_i,
   input logic             ier_rls_i,
   input logic             abeo_evt_i,
   input logic             ier_abeo_i
);

   // R2
   idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iir_o[0] |-> (iir_o[3:1] == 3'b000));

   // R3
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iir_o[0] |-> (iir_o[3:1] inside {3'b011, 3'b010, 3'b110, 3'b001}));

   // R5
   read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd_i && $past(iir_rd_i)) |-> $stable(iir_o));

   // R6
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_o[5:4] == 2'b00) && ((iir_o >> 10) == '0));

   // R4
   rls_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|rls_err_i) && ier_rls_i) |=> (irq_o || !ier_rls_i));

   // R7
   abeo_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abeo_evt_i && ier_abeo_i) |=> irq_o);

endmodule

bind uart_iid_ident uart_iid_chk #(.REG_W(REG_W), .N_ERR(N_ERR)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .iir_o      (iir_o),
   .irq_o      (irq_o),
   .iir_rd_i   (iir_rd_i),
   .rls_err_i  (rls_err_i),
   .ier_rls_i  (ier_rls_i),
   .abeo_evt_i (abeo_evt_i),
   .ier_abeo_i (ier_abeo_i)
);

// File: tb/uart_iid_ident_tb_top.sv
module uart_iid_ident_tb_top;

   localparam int unsigned REG_W = 32;
   localparam int unsigned N_ERR = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_ERR-1:0] rls_err_i = '0;
   logic             rda_i = 0, cti_i = 0, thre_i = 0, thr_wr_i = 0;
   logic             abeo_evt_i = 0, abto_evt_i = 0, abeo_clr_i = 0, abto_clr_i = 0;
   logic             ier_rls_i = 0, ier_rx_i = 0, ier_thre_i = 0;
   logic             ier_abeo_i = 0, ier_abto_i = 0;
   logic             fifo_en_i = 0, iir_rd_i = 0, lsr_rd_i = 0;
   logic [REG_W-1:0] iir_o;
   logic             irq_o;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   uart_iid_ident #(.REG_W(REG_W), .N_ERR(N_ERR)) dut_i (
      .clk(clk), .rst_n(rst_n), .rls_err_i(rls_err_i), .rda_i(rda_i),
      .cti_i(cti_i), .thre_i(thre_i), .thr_wr_i(thr_wr_i),
      .abeo_evt_i(abeo_evt_i), .abto_evt_i(abto_evt_i),
      .abeo_clr_i(abeo_clr_i), .abto_clr_i(abto_clr_i),
      .ier_rls_i(ier_rls_i), .ier_rx_i(ier_rx_i), .ier_thre_i(ier_thre_i),
      .ier_abeo_i(ier_abeo_i), .ier_abto_i(ier_abto_i),
      .fifo_en_i(fifo_en_i), .iir_rd_i(iir_rd_i), .lsr_rd_i(lsr_rd_i),
      .iir_o(iir_o), .irq_o(irq_o)
   );

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Priority model: line status 011 > data 010 > time-out 110 > tx empty 001
   function automatic logic [31:0] model(input logic [2:0] en, input logic [3:0] src,
                                         input logic fifo, input logic [1:0] ab);
      logic [2:0] code;
      logic       pend;
      pend = 1'b1;
      if (en[2] && src[3])      code = 3'b011;
      else if (en[1] && src[2]) code = 3'b010;
      else if (en[1] && src[1]) code = 3'b110;
      else if (en[0] && src[0]) code = 3'b001;
      else begin code = 3'b000; pend = 1'b0; end
      return (32'(ab) << 8) | (32'(fifo) * 32'hC0) | (32'(code) << 1) | 32'(!pend);
   endfunction

   task automatic do_read(input int hold);
      iir_rd_i = 1'b1;
      step(hold);
      iir_rd_i = 1'b0;
      step(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(2);
      // R1 reset state
      chk("R1 iir reset", iir_o, 32'h1);
      chk("R1 irq reset", 32'(irq_o), 32'h0);
      rst_n = 1'b1;
      step(2);
      chk("R1 iir after release", iir_o, 32'h1);

      // R2 R3 R6 R10 sweep over enables x sources
      for (int c = 0; c < 128; c++) begin
         logic [2:0] en;
         logic [3:0] src;
         logic       fifo;
         logic [31:0] exp;
         en   = 3'(c >> 4);
         src  = 4'(c);
         fifo = src[2] ^ en[1];
         ier_rls_i  = en[2];
         ier_rx_i   = en[1];
         ier_thre_i = en[0];
         fifo_en_i  = fifo;
         rls_err_i  = src[3] ? 4'(1 << (c % 4)) : 4'b0;
         rda_i      = src[2];
         cti_i      = src[1];
         thre_i     = src[0];
         step(1);
         rls_err_i = '0;
         step(2);
         exp = model(en, src, fifo, 2'b00);
         chk("R3 R2 R6 sweep iir", iir_o, exp);
         chk("R10 sweep irq", 32'(irq_o), 32'(!exp[0]));
         lsr_rd_i = 1'b1; thr_wr_i = 1'b1;
         rda_i = 1'b0; cti_i = 1'b0; thre_i = 1'b0;
         step(1);
         lsr_rd_i = 1'b0; thr_wr_i = 1'b0;
         step(2);
      end

      ier_rls_i = 1; ier_rx_i = 1; ier_thre_i = 1; fifo_en_i = 0;
      step(2);
      chk("R2 idle after sweep", iir_o, 32'h1);

      // R4 each error bit, survives identification read, cleared by line status read
      for (int b = 0; b < 4; b++) begin
         rls_err_i = 4'(1 << b);
         step(1);
         rls_err_i = '0;
         step(2);
         chk("R4 error bit raises line status", iir_o, 32'h6);
         do_read(1);
         chk("R4 not cleared by iir read", iir_o, 32'h6);
         lsr_rd_i = 1'b1;
         step(1);
         lsr_rd_i = 1'b0;
         step(2);
         chk("R4 cleared by lsr read", iir_o, 32'h1);
      end

      // R8 level sources
      rda_i = 1'b1;
      step(2);
      chk("R8 data available", iir_o, 32'h4);
      do_read(2);
      chk("R8 data survives read", iir_o, 32'h4);
      rda_i = 1'b0; cti_i = 1'b1;
      step(2);
      chk("R8 time-out", iir_o, 32'hC);
      do_read(1);
      chk("R8 time-out survives read", iir_o, 32'hC);
      cti_i = 1'b0;
      step(2);
      chk("R8 level dropped", iir_o, 32'h1);

      // R5 freeze and defer
      rda_i = 1'b1;
      step(2);
      iir_rd_i = 1'b1;
      step(1);
      rls_err_i = 4'b0100;
      step(1);
      rls_err_i = '0;
      step(1);
      chk("R5 frozen during read", iir_o, 32'h4);
      chk("R5 irq live during read", 32'(irq_o), 32'h1);
      step(1);
      chk("R5 still frozen", iir_o, 32'h4);
      iir_rd_i = 1'b0;
      step(1);
      chk("R5 deferred event after read", iir_o, 32'h6);
      rda_i = 1'b0; lsr_rd_i = 1'b1;
      step(1);
      lsr_rd_i = 1'b0;
      step(2);

      // R9 transmit empty clear paths
      thre_i = 1'b1;
      step(2);
      chk("R9 tx empty raised", iir_o, 32'h2);
      do_read(1);
      chk("R9 cleared by read showing 001", iir_o, 32'h1);
      chk("R9 irq after clear", 32'(irq_o), 32'h0);
      step(4);
      chk("R9 no re-arm without write", iir_o, 32'h1);
      thr_wr_i = 1'b1; thre_i = 1'b0;
      step(1);
      thr_wr_i = 1'b0; thre_i = 1'b1;
      step(2);
      chk("R9 re-armed after write", iir_o, 32'h2);
      rls_err_i = 4'b1000;
      step(1);
      rls_err_i = '0;
      step(2);
      chk("R9 masked by line status", iir_o, 32'h6);
      do_read(1);
      lsr_rd_i = 1'b1;
      step(1);
      lsr_rd_i = 1'b0;
      step(2);
      chk("R9 kept after read showing 011", iir_o, 32'h2);
      thr_wr_i = 1'b1; thre_i = 1'b0;
      step(1);
      thr_wr_i = 1'b0;
      step(2);
      chk("R9 cleared by write", iir_o, 32'h1);

      // R7 auto-baud flags
      ier_abeo_i = 1'b0;
      abeo_evt_i = 1'b1;
      step(1);
      abeo_evt_i = 1'b0;
      step(2);
      chk("R7 done ignored when disabled", iir_o, 32'h1);
      chk("R7 irq when disabled", 32'(irq_o), 32'h0);
      ier_abeo_i = 1'b1;
      abeo_evt_i = 1'b1;
      step(1);
      abeo_evt_i = 1'b0;
      step(2);
      chk("R7 done flag set", iir_o, 32'h101);
      chk("R7 done irq", 32'(irq_o), 32'h1);
      do_read(1);
      chk("R7 done survives read", iir_o, 32'h101);
      abeo_clr_i = 1'b1;
      step(1);
      abeo_clr_i = 1'b0;
      step(2);
      chk("R7 done cleared", iir_o, 32'h1);
      chk("R7 irq after done clear", 32'(irq_o), 32'h0);
      ier_abto_i = 1'b0;
      abto_evt_i = 1'b1;
      step(1);
      abto_evt_i = 1'b0;
      step(2);
      chk("R7 time-out ignored when disabled", iir_o, 32'h1);
      ier_abto_i = 1'b1; fifo_en_i = 1'b1;
      abto_evt_i = 1'b1;
      step(1);
      abto_evt_i = 1'b0;
      step(2);
      chk("R7 R6 time-out flag and fifo copy", iir_o, 32'h2C1);
      abto_clr_i = 1'b1;
      step(1);
      abto_clr_i = 1'b0;
      step(2);
      chk("R7 time-out cleared", iir_o, 32'hC1);
      chk("R10 irq idle", 32'(irq_o), 32'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule